// File: doc/BRIEF.md
# Indirect Colour LUT Register Window

This block is the processor-facing register slave of a colour lookup table whose storage is split into eight sub-RAMs. Software reads a fixed identification word, a version word and a row of build-parameter words. It sets an enable bit and a buffer-select bit in a control word. It reaches every sub-RAM through its own small window of four words: an address/commit word, a reserved word and two data words.

Writing a table entry takes two steps. Software first stages the entry value in the data words of a sub-RAM's window. It then writes that window's address word with the commit bit set, and the staged value lands at the given entry on that clock edge. When the table is double-banked, the processor always fills the bank that the pixel side is not using. A change of the buffer-select bit takes effect at the next start-of-frame pulse. A registered pixel-side read port stands in for the interpolation datapath.

Top module: `lut_indirect_regs`

## Requirements
- R1: Word offset 0x000 reads 0x6AF70165 (product 0x0165 in bits 15:0, vendor 0x6AF7 in bits 31:16). Offset 0x004 reads the major version in bits 31:16 and the minor version in bits 15:0 (default 0x00010000).
- R2: Offsets 0x00C, 0x010, 0x014, 0x018, 0x01C, 0x020, 0x024 and 0x028 return, zero-extended to 32 bits, the pixels-in-parallel count, input bits per sample, output bits per sample, alpha flag, LUT bits per colour, LUT lattice size, double-banking flag and readback flag.
- R3: The control word at 0x148 is read/write. Bit 0 is the enable and drives `lut_en`. Bit 1 is the buffer select. Bits 31:2 read as 0.
- R4: The address word of sub-RAM n (0x180 + 0x10*n) keeps bits 16:0 as the entry address and reads them back. Bit 28 (commit) and all other bits read as 0.
- R5: A write to the address word with bit 28 set stores the staged value of that sub-RAM at the given entry on the same edge. Without bit 28, only the address changes.
- R6: An entry is (alpha+3)*bits-per-colour wide. The low data word (0x188 + 0x10*n) stages bits 31:0. The high data word (0x18C + 0x10*n) stages the bits above 31. When the width is 32 or less, the high word is reserved.
- R7: With readback on, the low and high data words return the entry of the processor-side bank at the sub-RAM's current address, and 0 when that address is out of range.
- R8: With readback off, the data words return the staged values, masked to the entry width.
- R9: With double-banking, commits go to the bank opposite `pix_bank`. `pix_bank` takes the buffer-select bit only on an edge with `sof` high, using the select value held before that edge. Without double-banking, `pix_bank` stays 0.
- R10: Reserved offsets (0x008, 0x02C to 0x147, 0x14C to 0x17F, 0x184 + 0x10*n) read 0, and writes to them or to read-only words change nothing.
- R11: A commit whose address is not below the sub-RAM depth (default 16) stores nothing.
- R12: `pix_data` shows, one cycle after `pix_sel`/`pix_addr`, the entry of bank `pix_bank`. A commit on the same edge to the entry being read is not yet visible.
- R13: `cpu_rdata` is loaded on the edge where `cpu_rd` is high and holds otherwise. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_waddr | input | 7 | Word address (byte offset divided by 4) |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Registered read data |
| sof | input | 1 | Start-of-frame pulse, bank swap point |
| pix_sel | input | 3 | Pixel-side sub-RAM select |
| pix_addr | input | AW | Pixel-side entry address |
| pix_data | output | DW | Pixel-side registered entry |
| lut_en | output | 1 | LUT enable (0 means bypass) |
| pix_bank | output | 1 | Bank currently read by the pixel side |

## Verification
Two clashes can fall on one edge, and each is driven on purpose. In the first, a commit is issued in the same cycle as a `sof` pulse that swaps the banks. The bench expects the word to land in the bank that was inactive before the edge, and checks this by reading that entry from the pixel side right after the swap. In the second, on a single-bank build, the pixel port reads the very entry being committed. The bench expects the old value on the next cycle and the new value one cycle later.

// File: rtl/lut_indirect_regs.sv
module lut_indirect_regs #(
  parameter int PIXELS_PAR = 1,
  parameter int IN_BPS     = 10,
  parameter int OUT_BPS    = 10,
  parameter int HAS_ALPHA  = 1,
  parameter int BPC        = 10,
  parameter int LUT_DIM    = 17,
  parameter int DOUBLE_BUF = 1,
  parameter int CPU_READ   = 1,
  parameter int RAM_DEPTH  = 16,
  parameter logic [15:0] VER_MAJOR = 16'd1,
  parameter logic [15:0] VER_MINOR = 16'd0,
  localparam int DW = (HAS_ALPHA + 3) * BPC,
  localparam int AW = $clog2(RAM_DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [6:0]    cpu_waddr,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [31:0]   cpu_wdata,
  output logic [31:0]   cpu_rdata,
  input  logic          sof,
  input  logic [2:0]    pix_sel,
  input  logic [AW-1:0] pix_addr,
  output logic [DW-1:0] pix_data,
  output logic          lut_en,
  output logic          pix_bank
);
  localparam int NRAM   = 8;
  localparam int NB     = (DOUBLE_BUF != 0) ? 2 : 1;
  localparam int WORDS  = NB * NRAM * RAM_DEPTH;
  localparam int IW     = $clog2(WORDS);
  localparam bit HAS_HI = (DW > 32);
  localparam int HI_W   = HAS_HI ? DW - 32 : 1;
  localparam logic [31:0] LO_MASK = (DW >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << DW) - 64'd1);
  localparam logic [6:0] CTRL_WORD = 7'd82;

  logic [1:0]      ctrl_q;
  logic            bank_q;
  logic [16:0]     ent_addr_q [NRAM];
  logic [31:0]     stg_lo_q   [NRAM];
  logic [HI_W-1:0] stg_hi_q   [NRAM];
  logic [DW-1:0]   mem        [WORDS];

  function automatic logic [IW-1:0] idx(input logic b, input logic [2:0] n, input logic [AW-1:0] a);
    return IW'((32'(b) * NRAM + 32'(n)) * RAM_DEPTH + 32'(a));
  endfunction

  wire       ram_win  = (cpu_waddr[6:5] == 2'b11);
  wire [2:0] win_n    = cpu_waddr[4:2];
  wire [1:0] win_f    = cpu_waddr[1:0];
  wire       cpu_bank = (DOUBLE_BUF != 0) ? ~bank_q : 1'b0;
  wire       commit   = cpu_wr && ram_win && (win_f == 2'd0) && cpu_wdata[28]
                        && (cpu_wdata[16:0] < 17'(RAM_DEPTH));
  wire       rd_in_rng = ent_addr_q[win_n] < 17'(RAM_DEPTH);

  assign lut_en   = ctrl_q[0];
  assign pix_bank = bank_q;

  logic [31:0]   hi_ext;
  logic [63:0]   stg_full;
  logic [DW-1:0] wr_word;
  logic [63:0]   rd_ext;
  logic [31:0]   rd_val;

  always_comb begin
    hi_ext = '0;
    if (HAS_HI) hi_ext[HI_W-1:0] = stg_hi_q[win_n];
    stg_full = {hi_ext, stg_lo_q[win_n]};
    wr_word  = stg_full[DW-1:0];
    rd_ext   = '0;
    if (rd_in_rng) rd_ext = 64'(mem[idx(cpu_bank, win_n, ent_addr_q[win_n][AW-1:0])]);
  end

  always_comb begin
    rd_val = '0;
    case (cpu_waddr)
      7'd0:      rd_val = 32'h6AF7_0165;
      7'd1:      rd_val = {VER_MAJOR, VER_MINOR};
      7'd3:      rd_val = 32'(PIXELS_PAR);
      7'd4:      rd_val = 32'(IN_BPS);
      7'd5:      rd_val = 32'(OUT_BPS);
      7'd6:      rd_val = 32'(HAS_ALPHA);
      7'd7:      rd_val = 32'(BPC);
      7'd8:      rd_val = 32'(LUT_DIM);
      7'd9:      rd_val = 32'(DOUBLE_BUF);
      7'd10:     rd_val = 32'(CPU_READ);
      CTRL_WORD: rd_val = {30'd0, ctrl_q};
      default:
        if (ram_win) begin
          case (win_f)
            2'd0: rd_val = {15'd0, ent_addr_q[win_n]};
            2'd2: rd_val = (CPU_READ != 0) ? rd_ext[31:0] : stg_lo_q[win_n];
            2'd3: rd_val = !HAS_HI ? 32'd0 : (CPU_READ != 0) ? rd_ext[63:32] : hi_ext;
            default: rd_val = '0;
          endcase
        end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      bank_q    <= 1'b0;
      cpu_rdata <= '0;
      for (int i = 0; i < NRAM; i++) begin
        ent_addr_q[i] <= '0;
        stg_lo_q[i]   <= '0;
        stg_hi_q[i]   <= '0;
      end
    end else begin
      if (cpu_rd) cpu_rdata <= rd_val;
      if ((DOUBLE_BUF != 0) && sof) bank_q <= ctrl_q[1];
      if (cpu_wr) begin
        if (cpu_waddr == CTRL_WORD) ctrl_q <= cpu_wdata[1:0];
        if (ram_win) begin
          case (win_f)
            2'd0: ent_addr_q[win_n] <= cpu_wdata[16:0];
            2'd2: stg_lo_q[win_n]   <= cpu_wdata & LO_MASK;
            2'd3: if (HAS_HI) stg_hi_q[win_n] <= cpu_wdata[HI_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (commit) mem[idx(cpu_bank, win_n, cpu_wdata[AW-1:0])] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (rst) pix_data <= '0;
    else     pix_data <= mem[idx(bank_q, pix_sel, pix_addr)];
  end
endmodule

module lut_indirect_regs_chk (
  input logic        clk,
  input logic        rst,
  input logic [6:0]  cpu_waddr,
  input logic        cpu_wr,
  input logic        cpu_rd,
  input logic [31:0] cpu_wdata,
  input logic [31:0] cpu_rdata,
  input logic        sof,
  input logic        lut_en,
  input logic        pix_bank
);
  // R1
  id_word_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_waddr == 7'd0) |=> (cpu_rdata == 32'h6AF7_0165));
  // R3
  lut_en_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_waddr == 7'd82) |=> (lut_en == $past(cpu_wdata[0])));
  // R4
  commit_bit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_waddr[6:5] == 2'b11 && cpu_waddr[1:0] == 2'b00) |=> (cpu_rdata[31:17] == 15'd0));
  // R9
  bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sof |=> $stable(pix_bank));
  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_rd && cpu_waddr == 7'd2) |=> (cpu_rdata == 32'd0));
  // R13
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_rd |=> $stable(cpu_rdata));
endmodule

bind lut_indirect_regs lut_indirect_regs_chk u_chk (.*);

// File: tb/test_lut_indirect_regs.sv
module test_lut_indirect_regs;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WE = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  cpu_waddr = '0;
  logic        cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata, cpu_rdata2;
  logic        sof = 1'b0;
  logic [2:0]  pix_sel = '0;
  logic [3:0]  pix_addr = '0;
  logic [39:0] pix_data;
  logic [23:0] pix_data2;
  logic        lut_en, lut_en2, pix_bank, pix_bank2;

  int compared = 0, mismatched = 0;
  bit done = 0;
  string cur_req = "R13";

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_indirect_regs i_lut_indirect_regs (
    .clk, .rst, .cpu_waddr, .cpu_wr, .cpu_rd, .cpu_wdata, .cpu_rdata,
    .sof, .pix_sel, .pix_addr, .pix_data, .lut_en, .pix_bank);

  lut_indirect_regs #(.HAS_ALPHA(0), .BPC(8), .DOUBLE_BUF(0), .CPU_READ(0)) i_lut_indirect_regs_nr (
    .clk, .rst, .cpu_waddr, .cpu_wr, .cpu_rd, .cpu_wdata, .cpu_rdata(cpu_rdata2),
    .sof, .pix_sel, .pix_addr, .pix_data(pix_data2), .lut_en(lut_en2), .pix_bank(pix_bank2));

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // Behavioural reference for the default instance
  logic [39:0] m_mem [int];
  int          m_ctrl, m_bank;
  int          m_addr [8];
  logic [31:0] m_lo [8];
  logic [7:0]  m_hi [8];
  logic [31:0] e_rdata;
  bit          e_rdata_ok;
  logic [39:0] e_pix;
  bit          e_pix_ok;

  function automatic int key(int b, int n, int a);
    return b * 4096 + n * 256 + a;
  endfunction

  function automatic logic [31:0] m_read(input logic [6:0] w, output bit ok);
    int n, f, k;
    ok = 1;
    case (w)
      0: return 32'h6AF7_0165;
      1: return 32'h0001_0000;
      3: return 1;
      4: return 10;
      5: return 10;
      6: return 1;
      7: return 10;
      8: return 17;
      9: return 1;
      10: return 1;
      82: return 32'(m_ctrl);
      default: ;
    endcase
    if (w < 96) return 0;
    n = int'(w[4:2]);
    f = int'(w[1:0]);
    if (f == 0) return 32'(m_addr[n]);
    if (f == 1) return 0;
    if (m_addr[n] >= 16) return 0;
    k = key(1 - m_bank, n, m_addr[n]);
    if (!m_mem.exists(k)) begin ok = 0; return 0; end
    return (f == 2) ? m_mem[k][31:0] : {24'd0, m_mem[k][39:32]};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_mem.delete();
      m_ctrl = 0; m_bank = 0;
      for (int i = 0; i < 8; i++) begin m_addr[i] = 0; m_lo[i] = 0; m_hi[i] = 0; end
      e_rdata = 0; e_rdata_ok = 1; e_pix = 0; e_pix_ok = 1;
    end else begin
      int old_ctrl, n, k;
      old_ctrl = m_ctrl;
      if (cpu_rd) e_rdata = m_read(cpu_waddr, e_rdata_ok);
      k = key(m_bank, int'(pix_sel), int'(pix_addr));
      e_pix_ok = m_mem.exists(k);
      if (e_pix_ok) e_pix = m_mem[k];
      if (cpu_wr) begin
        n = int'(cpu_waddr[4:2]);
        if (cpu_waddr == 7'd82) m_ctrl = int'(cpu_wdata[1:0]);
        if (cpu_waddr >= 7'd96) begin
          case (cpu_waddr[1:0])
            2'd0: begin
              if (cpu_wdata[28] && cpu_wdata[16:0] < 17'd16)
                m_mem[key(1 - m_bank, n, int'(cpu_wdata[16:0]))] = {m_hi[n], m_lo[n]};
              m_addr[n] = int'(cpu_wdata[16:0]);
            end
            2'd2: m_lo[n] = cpu_wdata;
            2'd3: m_hi[n] = cpu_wdata[7:0];
            default: ;
          endcase
        end
      end
      if (sof) m_bank = (old_ctrl >> 1) & 1;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 lut_en", 64'(lut_en), 64'(m_ctrl & 1));
      chk("R9 pix_bank", 64'(pix_bank), 64'(m_bank));
      if (e_rdata_ok) chk({cur_req, " cpu_rdata"}, 64'(cpu_rdata), 64'(e_rdata));
      if (e_pix_ok) chk("R12 pix_data", 64'(pix_data), 64'(e_pix));
    end
  end

  task automatic wr(input logic [8:0] off, input logic [31:0] d, input bit s = 0);
    cpu_waddr = off[8:2]; cpu_wdata = d; cpu_wr = 1; sof = s;
    @(negedge clk);
    cpu_wr = 0; sof = 0;
  endtask

  task automatic rd(input logic [8:0] off, output logic [31:0] d1, output logic [31:0] d2);
    cpu_waddr = off[8:2]; cpu_rd = 1;
    @(negedge clk);
    cpu_rd = 0; d1 = cpu_rdata; d2 = cpu_rdata2;
  endtask

  task automatic rd_chk(input string req, input logic [8:0] off, input logic [31:0] exp);
    logic [31:0] a, b;
    rd(off, a, b);
    chk(req, 64'(a), 64'(exp));
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected finished");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R13 reset rdata", 64'(cpu_rdata), 0);
    chk("R3 reset lut_en", 64'(lut_en), 0);
    chk("R9 reset bank", 64'(pix_bank), 0);
    @(negedge clk);

    cur_req = "R1";
    rd_chk("R1 id", 9'h000, 32'h6AF7_0165);
    rd_chk("R1 version", 9'h004, 32'h0001_0000);

    cur_req = "R2";
    rd_chk("R2 pip", 9'h00C, 1);
    rd_chk("R2 in bps", 9'h010, 10);
    rd_chk("R2 alpha", 9'h018, 1);
    rd_chk("R2 lut bpc", 9'h01C, 10);
    rd_chk("R2 size", 9'h020, 17);
    rd_chk("R2 readable", 9'h028, 1);
    rd(9'h01C, a, b); chk("R2 bpc alt build", 64'(b), 8);
    rd(9'h018, a, b); chk("R2 alpha alt build", 64'(b), 0);

    cur_req = "R10";
    wr(9'h000, 32'hDEAD_BEEF);
    wr(9'h010, 32'h0000_0055);
    wr(9'h008, 32'h1234_5678);
    wr(9'h184, 32'hFFFF_FFFF);
    rd_chk("R10 ro id", 9'h000, 32'h6AF7_0165);
    rd_chk("R10 ro param", 9'h010, 10);
    rd_chk("R10 rsvd 008", 9'h008, 0);
    rd_chk("R10 rsvd 02C", 9'h02C, 0);
    rd_chk("R10 rsvd 14C", 9'h14C, 0);
    rd_chk("R10 rsvd 184", 9'h184, 0);

    cur_req = "R3";
    wr(9'h148, 32'hFFFF_FFFD);
    rd_chk("R3 ctrl", 9'h148, 32'h1);
    chk("R3 enable pin", 64'(lut_en), 1);

    cur_req = "R5";
    wr(9'h1A8, 32'h1234_5678);
    wr(9'h1AC, 32'h0000_00AB);
    wr(9'h1A0, WE | 32'd5);
    rd_chk("R4 addr readback, commit bit clear", 9'h1A0, 32'd5);
    cur_req = "R7";
    rd_chk("R7 low readback", 9'h1A8, 32'h1234_5678);
    rd_chk("R6 R7 high readback", 9'h1AC, 32'h0000_00AB);

    cur_req = "R9";
    wr(9'h148, 32'h3);
    chk("R9 no swap without sof", 64'(pix_bank), 0);
    pix_sel = 3'd2; pix_addr = 4'd5;
    @(negedge clk);
    chk("R9 still bank 0", 64'(pix_bank), 0);
    sof = 1; @(negedge clk); sof = 0;
    chk("R9 swap on sof", 64'(pix_bank), 1);
    @(negedge clk);
    chk("R12 R5 pixel sees committed entry", 64'(pix_data), 40'hAB_1234_5678);
    chk("R9 single bank holds", 64'(pix_bank2), 0);

    cur_req = "R11";
    wr(9'h1B8, 32'h0000_000A);
    wr(9'h1BC, 32'h0);
    wr(9'h1B0, WE | 32'd4);
    wr(9'h1B8, 32'h0000_000B);
    wr(9'h1B0, WE | 32'd20);
    rd_chk("R4 R11 out-of-range addr kept", 9'h1B0, 32'd20);
    rd_chk("R7 R11 out-of-range reads zero", 9'h1B8, 0);
    wr(9'h1B0, 32'd4);
    rd_chk("R5 R11 entry untouched", 9'h1B8, 32'h0000_000A);

    cur_req = "R9";
    wr(9'h148, 32'h1);
    wr(9'h198, 32'h0C0F_FEE0);
    wr(9'h19C, 32'h0000_005A);
    pix_sel = 3'd1; pix_addr = 4'd3;
    @(negedge clk);
    wr(9'h190, WE | 32'd3, 1);
    chk("R9 swap with commit", 64'(pix_bank), 0);
    @(negedge clk);
    chk("R9 R12 commit hit old inactive bank", 64'(pix_data), 40'h5A_0C0F_FEE0);

    cur_req = "R12";
    wr(9'h198, 32'h0011_1111);
    wr(9'h190, WE | 32'd3);
    chk("R12 read-before-write", 64'(pix_data2), 24'h0F_FEE0);
    @(negedge clk);
    chk("R12 new value next cycle", 64'(pix_data2), 24'h11_1111);

    cur_req = "R8";
    rd(9'h1A8, a, b);
    chk("R8 staged low masked", 64'(b), 32'h0034_5678);
    rd(9'h1AC, a, b);
    chk("R6 high reserved on narrow entry", 64'(b), 0);
    rd(9'h198, a, b);
    chk("R8 staged low latest", 64'(b), 32'h0011_1111);
    chk("R9 single bank after sof", 64'(pix_bank2), 0);

    cur_req = "R13";
    cpu_waddr = 7'd0;
    repeat (3) @(negedge clk);
    chk("R13 rdata holds", 64'(cpu_rdata), 32'h0011_1111);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule